// File: doc/BRIEF.md
# Prefix-Based Carry-Select Adder with Incrementer

This block adds two 64-bit operands and a carry-in, producing a 64-bit sum and a carry-out. The operands are cut into equal slices. Each slice is summed once with a parallel-prefix tree that assumes a zero carry-in. The result for a carry-in of one is not computed by a second adder. An incrementer adds one to the zero-carry result, including its carry-out bit, and a multiplexer picks between the two results. The carry that steers each multiplexer is the selected carry of the slice below, and the external carry-in steers the lowest slice. The selected carry of the top slice is the adder's carry-out.

The slice width is a parameter that must divide the total width. An optional output register, on by default, captures the sum and carry-out on the rising clock edge and clears them on a synchronous active-high reset. With the register off, the block is purely combinational and the clock and reset have no effect.

Top module: `csel_prefix_adder`

## Requirements
- R1: With OUT_REG=1, a high `rst` at a rising edge of `clk` makes `sum` all zeros and `cout` zero after that edge, whatever the operands.
- R2: With OUT_REG=1 and `rst` low, `sum` after a rising edge equals bits 63..0 of `a + b + cin` as sampled at that edge (a latency of one cycle).
- R3: `cout` carries bit 64 of the same 65-bit sum `a + b + cin`.
- R4: A carry-in of one with `a` all ones and `b` zero ripples through every slice: `sum` is all zeros and `cout` is 1.
- R5: With `a` and `b` both all ones and `cin` = 1, `sum` is all ones and `cout` is 1.
- R6: A carry produced inside one slice and passed through a following slice whose zero-carry sum is all ones reaches the slices above it; for example `a` = 0x0000_0000_FFFF_FF80, `b` = 0x80, `cin` = 0 gives `sum` = 0x0000_0001_0000_0000 and `cout` = 0.
- R7: The result does not depend on the slice width: slice widths of 4, 8 and 16 give identical `sum` and `cout` for the same inputs.
- R8: With OUT_REG=0, `sum` and `cout` equal the 65-bit sum of the current inputs in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| cin | input | 1 | Carry-in |
| sum | output | 64 | Low 64 bits of the sum |
| cout | output | 1 | Carry-out, bit 64 of the sum |

## Verification
The bench aims at carries that must cross slice boundaries. It uses a carry-in that ripples through all eight slices, the all-ones pair with a carry-in, and a carry produced in one slice that must pass through a neighbour whose zero-carry sum is all ones. An incrementer that dropped the carry-out bit of the zero-carry result, or a multiplexer steered by the wrong slice's carry, would give a wrong upper sum or a lost carry-out in exactly these cases. Random operands run on three slice widths and on the unregistered variant against a behavioural 65-bit addition. This exposes a prefix tree with a wrong span at any level, because such a fault corrupts bits only for some slice widths. A reset asserted in the middle of the run checks that the register clears rather than holds.

// File: rtl/csel_prefix_adder.sv
module csel_prefix_adder #(
  parameter int WIDTH   = 64,
  parameter int BLK     = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NB = WIDTH / BLK;
  localparam int LV = $clog2(BLK);

  if ((WIDTH % BLK) != 0 || BLK < 2) begin : g_bad_cfg
    $error("csel_prefix_adder: BLK must be at least 2 and divide WIDTH");
  end

  logic [NB:0]      bc;
  logic [WIDTH-1:0] s_c;

  assign bc[0] = cin;

  for (genvar bi = 0; bi < NB; bi++) begin : g_blk
    localparam int LO = bi * BLK;
    logic [BLK-1:0]         xa, xb;
    logic [LV:0][BLK-1:0]   gg, pp;
    logic [BLK:0]           z, one, run;
    logic                   pp_unused;

    assign xa    = a[LO +: BLK];
    assign xb    = b[LO +: BLK];
    assign gg[0] = xa & xb;
    assign pp[0] = xa ^ xb;

    for (genvar k = 1; k <= LV; k++) begin : g_lvl
      localparam int SP = 1 << (k - 1);
      for (genvar i = 0; i < BLK; i++) begin : g_bit
        if (i >= SP) begin : g_node
          assign gg[k][i] = gg[k-1][i] | (pp[k-1][i] & gg[k-1][i-SP]);
          assign pp[k][i] = pp[k-1][i] & pp[k-1][i-SP];
        end else begin : g_pass
          assign gg[k][i] = gg[k-1][i];
          assign pp[k][i] = pp[k-1][i];
        end
      end
    end
    assign pp_unused = ^pp[LV];

    assign z = {gg[LV][BLK-1], pp[0] ^ {gg[LV][BLK-2:0], 1'b0}};

    assign run[0] = 1'b1;
    for (genvar j = 0; j <= BLK; j++) begin : g_inc
      if (j < BLK) begin : g_chain
        assign run[j+1] = run[j] & z[j];
      end
      assign one[j] = z[j] ^ run[j];
    end

    assign {bc[bi+1], s_c[LO +: BLK]} = bc[bi] ? one : z;
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sum  <= '0;
        cout <= 1'b0;
      end else begin
        sum  <= s_c;
        cout <= bc[NB];
      end
    end
  end else begin : g_comb
    logic ctl_unused;
    assign ctl_unused = clk ^ rst;
    assign sum  = s_c;
    assign cout = bc[NB];
  end
endmodule

// File: rtl/csel_prefix_adder_chk.sv
module csel_prefix_adder_chk #(
  parameter int WIDTH   = 64,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);
  logic [WIDTH:0] full;
  assign full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  if (OUT_REG) begin : g_seq
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= !rst;

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
      (armed == 1'b0 && $past(rst)) |-> (sum == '0 && cout == 1'b0));

    assert_sum_matches_R2: assert property (@(posedge clk) disable iff (rst)
      armed |-> sum == $past(full[WIDTH-1:0]));

    assert_carry_out_R3: assert property (@(posedge clk) disable iff (rst)
      armed |-> cout == $past(full[WIDTH]));

    assert_ripple_through_R4: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(&a && b == '0 && cin)) |-> (sum == '0 && cout));

    assert_all_ones_R5: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(&a && &b && cin)) |-> (&sum && cout));
  end else begin : g_cmb
    assert_comb_result_R8: assert property (@(posedge clk) disable iff (rst)
      {cout, sum} == full);

    assert_comb_all_ones_R5: assert property (@(posedge clk) disable iff (rst)
      (&a && &b && cin) |-> (&sum && cout));

    assert_comb_ripple_R4: assert property (@(posedge clk) disable iff (rst)
      (&a && b == '0 && cin) |-> (sum == '0 && cout));

    assert_comb_carry_R3: assert property (@(posedge clk) disable iff (rst)
      cout == full[WIDTH]);
  end
endmodule

bind csel_prefix_adder csel_prefix_adder_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
);

// File: tb/csel_prefix_adder_tb.sv
`timescale 1ns/1ps
module csel_prefix_adder_tb;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;

  logic [W-1:0] s8, s4, s16, sc;
  logic         c8, c4, c16, cc;

  int    n_chk  = 0;
  int    n_fail = 0;
  string prev_tag = "R1";
  logic [W:0] exp_q = '0;

  always #10 clk = ~clk;

  csel_prefix_adder #(.WIDTH(W), .BLK(8), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(s8), .cout(c8));
  csel_prefix_adder #(.WIDTH(W), .BLK(4), .OUT_REG(1'b1)) u_b4 (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(s4), .cout(c4));
  csel_prefix_adder #(.WIDTH(W), .BLK(16), .OUT_REG(1'b1)) u_b16 (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(s16), .cout(c16));
  csel_prefix_adder #(.WIDTH(W), .BLK(8), .OUT_REG(1'b0)) u_comb (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sc), .cout(cc));

  always @(posedge clk)
    exp_q <= rst ? '0 : ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin});

  task automatic cmp(string tag, string who, logic [W:0] act, logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, who, act, exp);
    end
  endtask

  task automatic cmp_regs(string tag);
    cmp(tag, "blk8 (R2/R3)", {c8, s8}, exp_q);
    cmp({tag, " R7"}, "blk4", {c4, s4}, exp_q);
    cmp({tag, " R7"}, "blk16", {c16, s16}, exp_q);
  endtask

  task automatic apply(logic [W-1:0] va, logic [W-1:0] vb, logic vc, string tag);
    @(negedge clk);
    cmp_regs(prev_tag);
    a = va; b = vb; cin = vc; prev_tag = tag;
    #1;
    cmp({tag, " R8"}, "comb", {cc, sc},
        {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc});
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    a = {W{1'b1}}; b = {W{1'b1}}; cin = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R1", "reset blk8", {c8, s8}, '0);
    cmp("R1", "reset blk4", {c4, s4}, '0);
    rst = 1'b0;
    a = '0; b = '0; cin = 1'b0; prev_tag = "R2 zero";

    apply({W{1'b1}}, '0, 1'b1, "R4 ripple");
    apply({W{1'b1}}, {W{1'b1}}, 1'b1, "R5 all-ones");
    apply(64'h0000_0000_FFFF_FF80, 64'h80, 1'b0, "R6 cross-slice");
    apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1'b0, "R6 per-slice");
    apply(64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, "R3 no-cout");
    apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R3 cout");
    apply({W{1'b1}}, 64'h1, 1'b0, "R4 ripple-b");
    apply(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b1, "R2 mixed");

    @(negedge clk);
    cmp_regs(prev_tag);
    a = 64'hDEAD_BEEF_0000_1111; b = 64'h1; cin = 1'b1; rst = 1'b1;
    @(negedge clk);
    cmp("R1", "mid reset blk8", {c8, s8}, '0);
    cmp("R1", "mid reset blk16", {c16, s16}, '0);
    rst = 1'b0; a = '0; b = '0; cin = 1'b0; prev_tag = "R2 after reset";

    for (int i = 0; i < 300; i++)
      apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R2 random");
    for (int i = 0; i < W; i++)
      apply(~(64'h1 << i), 64'h1 << i, 1'b1, "R4 walking");

    @(negedge clk);
    cmp_regs(prev_tag);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule